// File: doc/BRIEF.md
# Paired Long-Word Load/Store Unit

This block moves two 32-bit signed integers between a pair of 40-bit data registers and a 64-bit memory data bus in one access. On a store it places the low 32 bits of both registers into the byte lanes of the write bus and asserts a write enable with all eight byte enables. On a load it takes the 64-bit read bus, splits it into two long words and presents them one cycle later as 40-bit register values. Each value is sign-extended into the guard bits, and a request to clear each destination's limit tag comes with it.

The first register of the pair always belongs to the long word at the effective address. The second belongs to the word at the effective address plus 4. An endian-mode input changes which half of the bus holds the lower address, so this pairing holds in both modes. A quad-word aligned address is required. Any other address raises a one-cycle fault and blocks every write. Address generation and address update are done elsewhere.

Top module: `pair_ldst_unit`

## Requirements
- R1: In little-endian mode (`big_endian`=0), an aligned store drives `wr_data[31:0]` with `reg_a[31:0]` and `wr_data[63:32]` with `reg_b[31:0]`, in the same cycle as the request.
- R2: In big-endian mode (`big_endian`=1), an aligned store drives `wr_data[63:32]` with `reg_a[31:0]` and `wr_data[31:0]` with `reg_b[31:0]`.
- R3: Bits 39..32 of the source registers have no effect on `wr_data`.
- R4: An aligned store (`req_valid`=1, `req_load`=0, `ea[2:0]`=0) asserts `wr_en` and drives `wr_be`=8'hFF. In every other cycle `wr_en`=0 and `wr_be`=8'h00.
- R5: In little-endian mode, an aligned load takes `rd_data[31:0]` into `ld_data_a` and `rd_data[63:32]` into `ld_data_b`. `rd_data` is sampled in the request cycle, and the results appear with `ld_valid`=1 exactly one cycle later.
- R6: In big-endian mode, an aligned load takes `rd_data[63:32]` into `ld_data_a` and `rd_data[31:0]` into `ld_data_b`.
- R7: On a load, bits 39..32 of each result are copies of bit 31 of the loaded word.
- R8: `ld_lim_clr` (bit 0 for register A, bit 1 for register B) is 2'b11 exactly in the cycles where `ld_valid`=1, and 2'b00 otherwise.
- R9: A request whose `ea[2:0]` is nonzero raises `align_fault` for exactly one cycle, one cycle after the request. It asserts neither `wr_en` nor `ld_valid`.
- R10: After reset, and in cycles without a request, `ld_valid`, `ld_lim_clr`, `align_fault` and `wr_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Transfer request in this cycle |
| req_load | input | 1 | 1: memory to registers; 0: registers to memory |
| big_endian | input | 1 | 1: big-endian lane mapping; 0: little-endian |
| ea | input | 32 | Effective byte address |
| reg_a | input | 40 | First source register (lower address) |
| reg_b | input | 40 | Second source register (address + 4) |
| rd_data | input | 64 | Memory read bus, valid in the load request cycle |
| wr_data | output | 64 | Memory write bus |
| wr_en | output | 1 | Memory write enable |
| wr_be | output | 8 | Byte enables of the write |
| ld_valid | output | 1 | Load results valid |
| ld_data_a | output | 40 | Sign-extended word from the lower address |
| ld_data_b | output | 40 | Sign-extended word from address + 4 |
| ld_lim_clr | output | 2 | Clear the limit tag of destination A (bit 0) and B (bit 1) |
| align_fault | output | 1 | One-cycle pulse after a misaligned request |

## Verification
Stores are tried with distinct values in both modes, which shows whether the two bus halves are swapped by mode or fixed. Stores also use registers whose guard bits are nonzero, so any leak of bits 39..32 onto the bus shows. Loads use one positive and one negative word in each mode, so wrong half selection and wrong sign extension each produce a different result. Misaligned stores and loads at offsets 4 and 1 show the fault pulse and the blocked writes. A store followed by a load of the same bus image must return the original values.

// File: rtl/pls_pkg.sv
package pls_pkg;
  localparam int unsigned PLS_WORD_W  = 32;
  localparam int unsigned PLS_REG_W   = 40;
  localparam int unsigned PLS_NWORDS  = 2;
  localparam int unsigned PLS_ADDR_W  = 32;
  localparam int unsigned PLS_BUS_W   = PLS_WORD_W * PLS_NWORDS;
  localparam int unsigned PLS_NBYTES  = PLS_BUS_W / 8;
  localparam int unsigned PLS_ALIGN_W = $clog2(PLS_NBYTES);
endpackage

// File: rtl/pls_align_chk.sv
module pls_align_chk #(
  parameter int unsigned ADDR_W  = pls_pkg::PLS_ADDR_W,
  parameter int unsigned ALIGN_W = pls_pkg::PLS_ALIGN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] ea,
  output logic              aligned,
  output logic              fault
);
  logic fault_d, fault_q;

  always_comb begin
    aligned = (ea[ALIGN_W-1:0] == '0);
    fault_d = req_valid && !aligned;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault_d;
  end

  assign fault = fault_q;

  AST_FAULT_AFTER_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ea[ALIGN_W-1:0] != '0) |=> fault); // R9
  AST_FAULT_ONLY_ON_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && ea[ALIGN_W-1:0] != '0) |=> !fault); // R9
endmodule

// File: rtl/pls_store_map.sv
module pls_store_map #(
  parameter int unsigned WORD_W = pls_pkg::PLS_WORD_W,
  parameter int unsigned REG_W  = pls_pkg::PLS_REG_W,
  parameter int unsigned NWORDS = pls_pkg::PLS_NWORDS,
  localparam int unsigned BUS_W = WORD_W * NWORDS
) (
  input  logic                    big_endian,
  input  logic [NWORDS*REG_W-1:0] src_regs,
  output logic [BUS_W-1:0]        bus
);
  always_comb begin
    bus = '0;
    for (int i = 0; i < NWORDS; i++) begin
      // Lower-address word sits in the low lanes for little endian, high lanes for big endian.
      if (big_endian)
        bus[(NWORDS-1-i)*WORD_W +: WORD_W] = src_regs[i*REG_W +: WORD_W];
      else
        bus[i*WORD_W +: WORD_W] = src_regs[i*REG_W +: WORD_W];
    end
  end
endmodule

// File: rtl/pls_load_unpack.sv
module pls_load_unpack #(
  parameter int unsigned WORD_W = pls_pkg::PLS_WORD_W,
  parameter int unsigned REG_W  = pls_pkg::PLS_REG_W,
  parameter int unsigned NWORDS = pls_pkg::PLS_NWORDS,
  localparam int unsigned BUS_W = WORD_W * NWORDS,
  localparam int unsigned EXT_W = REG_W - WORD_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_fire,
  input  logic                    big_endian,
  input  logic [BUS_W-1:0]        bus,
  output logic                    res_valid,
  output logic [NWORDS*REG_W-1:0] res_regs,
  output logic [NWORDS-1:0]       res_lim_clr
);
  logic [NWORDS*REG_W-1:0] regs_d, regs_q;
  logic                    valid_q;
  logic [NWORDS-1:0]       lim_q;

  always_comb begin
    regs_d = '0;
    for (int i = 0; i < NWORDS; i++) begin
      logic [WORD_W-1:0] word;
      word = big_endian ? bus[(NWORDS-1-i)*WORD_W +: WORD_W] : bus[i*WORD_W +: WORD_W];
      regs_d[i*REG_W +: REG_W] = {{EXT_W{word[WORD_W-1]}}, word};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= load_fire;
  end

  for (genvar g = 0; g < NWORDS; g++) begin : g_lim
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lim_q[g] <= 1'b0;
      else        lim_q[g] <= load_fire;
    end
  end

  always_ff @(posedge clk) begin
    if (load_fire) regs_q <= regs_d;
  end

  assign res_valid   = valid_q;
  assign res_regs    = regs_q;
  assign res_lim_clr = lim_q;

  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> res_valid); // R5
  AST_SIGN_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_regs[REG_W-1:WORD_W] == {EXT_W{res_regs[WORD_W-1]}})); // R7
  AST_LIMCLR_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    res_lim_clr == (res_valid ? {NWORDS{1'b1}} : {NWORDS{1'b0}})); // R8
endmodule

// File: rtl/pair_ldst_unit.sv
module pair_ldst_unit #(
  parameter int unsigned WORD_W = pls_pkg::PLS_WORD_W,
  parameter int unsigned REG_W  = pls_pkg::PLS_REG_W,
  parameter int unsigned ADDR_W = pls_pkg::PLS_ADDR_W,
  localparam int unsigned NWORDS  = 2,
  localparam int unsigned BUS_W   = WORD_W * NWORDS,
  localparam int unsigned NBYTES  = BUS_W / 8,
  localparam int unsigned ALIGN_W = $clog2(NBYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_load,
  input  logic              big_endian,
  input  logic [ADDR_W-1:0] ea,
  input  logic [REG_W-1:0]  reg_a,
  input  logic [REG_W-1:0]  reg_b,
  input  logic [BUS_W-1:0]  rd_data,
  output logic [BUS_W-1:0]  wr_data,
  output logic              wr_en,
  output logic [NBYTES-1:0] wr_be,
  output logic              ld_valid,
  output logic [REG_W-1:0]  ld_data_a,
  output logic [REG_W-1:0]  ld_data_b,
  output logic [1:0]        ld_lim_clr,
  output logic              align_fault
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       aligned;
  logic       store_fire, load_fire;
  logic [NWORDS*REG_W-1:0] ld_regs;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pls_align_chk #(.ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W)) u_align (
    .clk(clk), .rst_n(rst_int_n), .req_valid(req_valid), .ea(ea),
    .aligned(aligned), .fault(align_fault)
  );

  always_comb begin
    store_fire = req_valid && !req_load && aligned && rst_int_n;
    load_fire  = req_valid &&  req_load && aligned && rst_int_n;
    wr_en      = store_fire;
    wr_be      = store_fire ? {NBYTES{1'b1}} : {NBYTES{1'b0}};
  end

  pls_store_map #(.WORD_W(WORD_W), .REG_W(REG_W), .NWORDS(NWORDS)) u_store (
    .big_endian(big_endian), .src_regs({reg_b, reg_a}), .bus(wr_data)
  );

  pls_load_unpack #(.WORD_W(WORD_W), .REG_W(REG_W), .NWORDS(NWORDS)) u_load (
    .clk(clk), .rst_n(rst_int_n), .load_fire(load_fire), .big_endian(big_endian),
    .bus(rd_data), .res_valid(ld_valid), .res_regs(ld_regs), .res_lim_clr(ld_lim_clr)
  );

  assign ld_data_a = ld_regs[0 +: REG_W];
  assign ld_data_b = ld_regs[REG_W +: REG_W];

  AST_WE_FULL_BYTES: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_en |-> (wr_be == {NBYTES{1'b1}})); // R4
  AST_NO_WE_MISALIGN: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ea[ALIGN_W-1:0] != '0) |-> !wr_en); // R9
  AST_NO_WE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!req_valid || req_load) |-> (!wr_en && wr_be == '0)); // R4
  AST_FAULT_BLOCKS_LOAD: assert property (@(posedge clk) disable iff (!rst_int_n)
    align_fault |-> !ld_valid); // R9
  AST_STORE_LOW_WORD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && !big_endian) |-> (wr_data[WORD_W-1:0] == reg_a[WORD_W-1:0])); // R1
endmodule

// File: tb/sim_pair_ldst_unit.sv
module sim_pair_ldst_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_load, big_endian;
  logic [31:0] ea;
  logic [39:0] reg_a, reg_b;
  logic [63:0] rd_data;
  logic [63:0] wr_data;
  logic        wr_en;
  logic [7:0]  wr_be;
  logic        ld_valid;
  logic [39:0] ld_data_a, ld_data_b;
  logic [1:0]  ld_lim_clr;
  logic        align_fault;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pair_ldst_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_load(req_load),
    .big_endian(big_endian), .ea(ea), .reg_a(reg_a), .reg_b(reg_b),
    .rd_data(rd_data), .wr_data(wr_data), .wr_en(wr_en), .wr_be(wr_be),
    .ld_valid(ld_valid), .ld_data_a(ld_data_a), .ld_data_b(ld_data_b),
    .ld_lim_clr(ld_lim_clr), .align_fault(align_fault)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_bus(input bit be, input logic [39:0] a, input logic [39:0] b);
    return be ? {a[31:0], b[31:0]} : {b[31:0], a[31:0]};
  endfunction

  function automatic logic [39:0] sext(input logic [31:0] w);
    return {{8{w[31]}}, w};
  endfunction

  task automatic idle_inputs();
    req_valid = 0; req_load = 0; ea = '0;
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    check("R10 ld_valid", ld_valid, 0);
    check("R10 ld_lim_clr", ld_lim_clr, 0);
    check("R10 align_fault", align_fault, 0);
    check("R10 wr_en", wr_en, 0);
  endtask

  task automatic t_store(input bit be, input logic [39:0] a, input logic [39:0] b, input string req);
    @(negedge clk);
    req_valid = 1; req_load = 0; big_endian = be; ea = 32'h0000_1040; reg_a = a; reg_b = b;
    #2;
    check({req, " wr_data"}, wr_data, exp_bus(be, a, b));
    check("R4 wr_en", wr_en, 1);
    check("R4 wr_be", wr_be, 8'hFF);
    @(negedge clk); idle_inputs(); #1;
    check("R4 wr_en idle", wr_en, 0);
    check("R4 wr_be idle", wr_be, 8'h00);
    check("R9 no fault aligned store", align_fault, 0);
  endtask

  task automatic t_load(input bit be, input logic [63:0] rd, input string req);
    logic [39:0] ea_exp, eb_exp;
    ea_exp = be ? sext(rd[63:32]) : sext(rd[31:0]);
    eb_exp = be ? sext(rd[31:0])  : sext(rd[63:32]);
    @(negedge clk);
    req_valid = 1; req_load = 1; big_endian = be; ea = 32'h0000_2008; rd_data = rd;
    #2;
    check("R4 no write on load", wr_en, 0);
    check("R5 not yet valid", ld_valid, 0);
    @(negedge clk); idle_inputs(); rd_data = '1; #1;
    check("R5 ld_valid", ld_valid, 1);
    check({req, " R7 ld_data_a"}, ld_data_a, ea_exp);
    check({req, " R7 ld_data_b"}, ld_data_b, eb_exp);
    check("R8 lim_clr", ld_lim_clr, 2'b11);
    @(negedge clk); #1;
    check("R5 valid one cycle", ld_valid, 0);
    check("R8 lim_clr drops", ld_lim_clr, 2'b00);
  endtask

  task automatic t_misaligned(input bit load, input logic [31:0] addr);
    @(negedge clk);
    req_valid = 1; req_load = load; big_endian = 0; ea = addr;
    reg_a = 40'h00_1111_1111; reg_b = 40'h00_2222_2222; rd_data = 64'h8000_0000_8000_0000;
    #2;
    check("R9 no wr_en misaligned", wr_en, 0);
    check("R9 no wr_be misaligned", wr_be, 0);
    @(negedge clk); idle_inputs(); #1;
    check("R9 fault raised", align_fault, 1);
    check("R9 no ld_valid", ld_valid, 0);
    check("R9 no lim_clr", ld_lim_clr, 0);
    @(negedge clk); #1;
    check("R9 fault one cycle", align_fault, 0);
    check("R9 still no ld_valid", ld_valid, 0);
  endtask

  task automatic t_roundtrip(input bit be, input logic [39:0] a, input logic [39:0] b);
    logic [63:0] img;
    @(negedge clk);
    req_valid = 1; req_load = 0; big_endian = be; ea = 32'h0000_3000; reg_a = a; reg_b = b;
    #2; img = wr_data;
    @(negedge clk);
    req_load = 1; rd_data = img;
    @(negedge clk); idle_inputs(); #1;
    check(be ? "R6 roundtrip a" : "R5 roundtrip a", ld_data_a, sext(a[31:0]));
    check(be ? "R6 roundtrip b" : "R5 roundtrip b", ld_data_b, sext(b[31:0]));
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle_inputs(); big_endian = 0;
    reg_a = '0; reg_b = '0; rd_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_store(0, 40'h00_A1B2_C3D4, 40'h00_1122_3344, "R1");
    t_store(1, 40'h00_A1B2_C3D4, 40'h00_1122_3344, "R2");
    t_store(0, 40'hFF_0000_0001, 40'h5A_7FFF_FFFE, "R3 guard ignored LE");
    t_store(1, 40'h80_1234_5678, 40'h01_8765_4321, "R3 guard ignored BE");
    t_load(0, 64'h7654_3210_8000_0001, "R5");
    t_load(1, 64'h7654_3210_8000_0001, "R6");
    t_load(1, 64'hFFFF_FFFE_0000_7FFF, "R6 negative");
    t_misaligned(0, 32'h0000_1004);
    t_misaligned(1, 32'h0000_1001);
    t_roundtrip(0, 40'hFF_F000_0000, 40'h00_0000_1234);
    t_roundtrip(1, 40'h00_0ABC_DEF0, 40'hFF_8000_0000);
    t_reset();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule